// File: doc/BRIEF.md
# Two-Minute BCD Stopwatch Core

This block keeps elapsed time as a minutes digit and two decimal seconds digits. It counts from 0:00 to 1:59 and then wraps to 0:00 and keeps going. It runs from one system clock. Time advances by one second on each clock edge where a one-cycle seconds strobe is high and the watch is running. Whatever produces the strobe is outside the block.

A start/stop request input is watched for rising edges, and each rising edge flips the running state. A clear request puts the time back to 0:00 without changing the running state. The three digits are truncated counters with moduli ten, six and two, chained so that each one steps only when all lower digits are at their top value. The digits come out as BCD, ready for a display decoder that lives elsewhere.

Top module: `sw_stopwatch`

## Requirements
- R1: Reset is synchronous and active-high. After a reset cycle all three digits read 0 and `running_o` is 0.
- R2: On a counted tick (`tick_i` = 1 and `running_o` = 1 before the edge, `clear_i` = 0), the units digit goes up by one from 0 to 8, and goes from 9 to 0.
- R3: The tens digit goes up by one only on a counted tick where units is 9, and goes from 5 to 0. On every other counted tick it keeps its value.
- R4: The minutes digit goes up only on a counted tick at 0:59. A counted tick at 1:59 gives 0:00.
- R5: With `tick_i` = 0, or with the watch stopped, the digits keep their value from one edge to the next.
- R6: A 0-to-1 change of `start_stop_i`, sampled on clock edges, flips `running_o` at that edge. Holding the input high causes no further change, and a low level does nothing.
- R7: When `clear_i` is 1 at an edge, the digits become 0:00 at that edge, even if a counted tick is present in the same cycle. `running_o` is not affected by the clear.
- R8: Units never leaves 0..9, tens never leaves 0..5, and minutes never leaves 0..1.
- R9: The displayed time, minutes*60 + tens*10 + units, always equals the number of counted ticks since the last clear or reset, taken modulo 120.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle seconds strobe |
| clear_i | input | 1 | Return time to 0:00 |
| start_stop_i | input | 1 | Rising edge flips the running state |
| min_o | output | 1 | Minutes digit (0..1) |
| tens_o | output | 3 | Tens-of-seconds BCD digit (0..5) |
| units_o | output | 4 | Units-of-seconds BCD digit (0..9) |
| running_o | output | 1 | 1 while the watch is counting |

## Verification
The bench steps through the carry boundaries at x:x9, 0:59 and 1:59.
- A carry with a wrong condition would let tens reach 6, or would make minutes step at 0:09 instead of 0:59.
- A missing wrap would show 2:00, or put a stray minute on the display.

It applies a clear and a counted tick in the same cycle. A design with the wrong priority would show 0:01, or would lose or flip the running state.

It holds start/stop high for several cycles. A level-sensitive design would flip the running state on every cycle.

It also sends ticks while the watch is stopped, and the display must not move.

// File: rtl/sw_pkg.sv
package sw_pkg;

    localparam int UNITS_MOD = 10;
    localparam int TENS_MOD  = 6;
    localparam int MIN_MOD   = 2;

    localparam int UNITS_W = $clog2(UNITS_MOD);
    localparam int TENS_W  = $clog2(TENS_MOD);
    localparam int MIN_W   = (MIN_MOD > 2) ? $clog2(MIN_MOD) : 1;

    typedef struct packed {
        logic [MIN_W-1:0]   mins;
        logic [TENS_W-1:0]  tens;
        logic [UNITS_W-1:0] units;
    } sw_time_t;

    typedef enum logic {
        SW_STOPPED = 1'b0,
        SW_RUNNING = 1'b1
    } sw_state_t;

    function automatic sw_state_t sw_flip(input sw_state_t s);
        return (s == SW_RUNNING) ? SW_STOPPED : SW_RUNNING;
    endfunction

endpackage

// File: rtl/sw_mod_digit.sv
module sw_mod_digit #(
    parameter int MOD = 10,
    parameter int W   = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] val,
    output logic         at_top
);
    localparam logic [W-1:0] TOP = W'(MOD - 1);

    logic [W-1:0] val_q;
    logic [W-1:0] val_d;

    assign at_top = (val_q == TOP);

    always_comb begin
        val_d = val_q;
        if (clr) begin
            val_d = '0;
        end else if (inc) begin
            val_d = at_top ? '0 : val_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) val_q <= '0;
        else     val_q <= val_d;
    end

    assign val = val_q;
endmodule

// File: rtl/sw_run_ctrl.sv
module sw_run_ctrl
    import sw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic btn,
    output logic running
);
    logic      btn_prev_q;
    logic      btn_rise;
    sw_state_t state_q;
    sw_state_t state_d;

    assign btn_rise = btn & ~btn_prev_q;

    always_comb begin
        state_d = state_q;
        if (btn_rise) state_d = sw_flip(state_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            btn_prev_q <= 1'b0;
            state_q    <= SW_STOPPED;
        end else begin
            btn_prev_q <= btn;
            state_q    <= state_d;
        end
    end

    assign running = (state_q == SW_RUNNING);
endmodule

// File: rtl/sw_stopwatch.sv
module sw_stopwatch
    import sw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             clear_i,
    input  logic             start_stop_i,
    output logic [MIN_W-1:0] min_o,
    output logic [TENS_W-1:0] tens_o,
    output logic [UNITS_W-1:0] units_o,
    output logic             running_o
);
    sw_time_t now;
    logic     running;
    logic     count_en;
    logic     units_top;
    logic     tens_top;
    logic     mins_top;
    logic     tens_inc;
    logic     mins_inc;

    sw_run_ctrl u_run (
        .clk     (clk),
        .rst     (rst),
        .btn     (start_stop_i),
        .running (running)
    );

    assign count_en = tick_i & running;
    assign tens_inc = count_en & units_top;
    assign mins_inc = tens_inc & tens_top;

    sw_mod_digit #(.MOD(UNITS_MOD), .W(UNITS_W)) u_units (
        .clk    (clk),
        .rst    (rst),
        .clr    (clear_i),
        .inc    (count_en),
        .val    (now.units),
        .at_top (units_top)
    );

    sw_mod_digit #(.MOD(TENS_MOD), .W(TENS_W)) u_tens (
        .clk    (clk),
        .rst    (rst),
        .clr    (clear_i),
        .inc    (tens_inc),
        .val    (now.tens),
        .at_top (tens_top)
    );

    sw_mod_digit #(.MOD(MIN_MOD), .W(MIN_W)) u_mins (
        .clk    (clk),
        .rst    (rst),
        .clr    (clear_i),
        .inc    (mins_inc),
        .val    (now.mins),
        .at_top (mins_top)
    );

    assign min_o     = now.mins;
    assign tens_o    = now.tens;
    assign units_o   = now.units;
    assign running_o = running;
endmodule

// File: rtl/sw_stopwatch_chk.sv
module sw_stopwatch_chk
    import sw_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               tick_i,
    input logic               clear_i,
    input logic               start_stop_i,
    input logic [MIN_W-1:0]   min_o,
    input logic [TENS_W-1:0]  tens_o,
    input logic [UNITS_W-1:0] units_o,
    input logic               running_o
);
    logic counted;
    assign counted = tick_i && running_o && !clear_i;

    p_units_range_r8: assert property (@(posedge clk) disable iff (rst)
        units_o <= UNITS_W'(UNITS_MOD - 1));

    p_tens_range_r8: assert property (@(posedge clk) disable iff (rst)
        tens_o <= TENS_W'(TENS_MOD - 1));

    p_units_step_r2: assert property (@(posedge clk) disable iff (rst)
        counted |=> units_o == (($past(units_o) == UNITS_W'(UNITS_MOD - 1))
                                ? '0 : $past(units_o) + UNITS_W'(1)));

    p_tens_hold_r3: assert property (@(posedge clk) disable iff (rst)
        counted && units_o != UNITS_W'(UNITS_MOD - 1) |=> $stable(tens_o));

    p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        counted && min_o == MIN_W'(MIN_MOD - 1) && tens_o == TENS_W'(TENS_MOD - 1)
        && units_o == UNITS_W'(UNITS_MOD - 1)
        |=> min_o == '0 && tens_o == '0 && units_o == '0);

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!tick_i || !running_o) && !clear_i
        |=> $stable(units_o) && $stable(tens_o) && $stable(min_o));

    p_toggle_r6: assert property (@(posedge clk) disable iff (rst)
        start_stop_i && !$past(start_stop_i) && !$past(rst)
        |=> running_o != $past(running_o));

    p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> min_o == '0 && tens_o == '0 && units_o == '0);

    p_clear_run_r7: assert property (@(posedge clk) disable iff (rst)
        clear_i && !start_stop_i |=> $stable(running_o));
endmodule

bind sw_stopwatch sw_stopwatch_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick_i       (tick_i),
    .clear_i      (clear_i),
    .start_stop_i (start_stop_i),
    .min_o        (min_o),
    .tens_o       (tens_o),
    .units_o      (units_o),
    .running_o    (running_o)
);

// File: tb/tb_sw_stopwatch.sv
`timescale 1ns/1ps
module tb_sw_stopwatch;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       clear_i = 1'b0;
    logic       start_stop_i = 1'b0;
    logic       min_o;
    logic [2:0] tens_o;
    logic [3:0] units_o;
    logic       running_o;

    int n_cmp = 0;
    int n_bad = 0;
    int ref_secs = 0;
    bit ref_run = 1'b0;
    bit ref_prev = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sw_stopwatch dut (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick_i),
        .clear_i      (clear_i),
        .start_stop_i (start_stop_i),
        .min_o        (min_o),
        .tens_o       (tens_o),
        .units_o      (units_o),
        .running_o    (running_o)
    );

    task automatic check(input string tag);
        int got;
        got = int'(min_o) * 60 + int'(tens_o) * 10 + int'(units_o);
        n_cmp++;
        if (int'(units_o) > 9 || int'(tens_o) > 5) begin
            n_bad++;
            $display("FAIL R8 (%s): digits out of range %0d:%0d%0d", tag, min_o, tens_o, units_o);
        end else if (got != ref_secs) begin
            n_bad++;
            $display("FAIL %s R9: time %0d expected %0d", tag, got, ref_secs);
        end else if (running_o != ref_run) begin
            n_bad++;
            $display("FAIL %s: running %0d expected %0d", tag, running_o, ref_run);
        end
    endtask

    task automatic step(input bit t, input bit c, input bit s, input string tag);
        bit rise;
        @(negedge clk);
        tick_i = t; clear_i = c; start_stop_i = s;
        @(posedge clk);
        rise = s && !ref_prev;
        if (c) ref_secs = 0;
        else if (t && ref_run) ref_secs = (ref_secs + 1) % 120;
        if (rise) ref_run = !ref_run;
        ref_prev = s;
        #1 check(tag);
    endtask

    task automatic expect_time(input int m, input int tn, input int u, input string tag);
        n_cmp++;
        if (int'(min_o) != m || int'(tens_o) != tn || int'(units_o) != u) begin
            n_bad++;
            $display("FAIL %s: time %0d:%0d%0d expected %0d:%0d%0d",
                     tag, min_o, tens_o, units_o, m, tn, u);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.5;
        check("R1 reset");
        expect_time(0, 0, 0, "R1 reset digits");

        for (int i = 0; i < 5; i++) step(1, 0, 0, "R5 stopped ticks");
        step(1, 0, 1, "R6 start press");
        for (int i = 0; i < 4; i++) step(0, 0, 1, "R6 held high");
        step(0, 0, 0, "R6 release");
        for (int i = 0; i < 3; i++) step(0, 0, 0, "R5 no tick");

        for (int i = 0; i < 12; i++) begin
            step(1, 0, 0, "R2 counting");
            step(0, 0, 0, "R5 gap");
        end
        expect_time(0, 1, 2, "R3 twelve seconds");

        while (ref_secs != 59) step(1, 0, 0, "R3 toward 0:59");
        expect_time(0, 5, 9, "R3 at 0:59");
        step(1, 0, 0, "R4 minute carry");
        expect_time(1, 0, 0, "R4 1:00");

        while (ref_secs != 119) step(1, 0, 0, "R2 toward 1:59");
        expect_time(1, 5, 9, "R4 at 1:59");
        step(1, 0, 0, "R4 wrap");
        expect_time(0, 0, 0, "R4 wrap to 0:00");
        for (int i = 0; i < 7; i++) step(1, 0, 0, "R9 after wrap");

        step(1, 0, 1, "R6 stop press");
        for (int i = 0; i < 6; i++) step(1, 0, 0, "R5 stopped with ticks");
        expect_time(0, 0, 8, "R5 frozen");

        step(0, 0, 1, "R6 restart");
        step(0, 0, 0, "R6 release");
        for (int i = 0; i < 30; i++) step(1, 0, 0, "R9 counting");
        step(1, 1, 0, "R7 clear with tick");
        expect_time(0, 0, 0, "R7 clear priority");
        for (int i = 0; i < 3; i++) step(1, 0, 0, "R7 run kept");

        step(0, 0, 1, "R6 stop");
        step(0, 1, 0, "R7 clear while stopped");
        step(1, 0, 0, "R7 still stopped");
        expect_time(0, 0, 0, "R7 stopped after clear");

        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        ref_secs = 0; ref_run = 0; ref_prev = 0;
        @(negedge clk);
        rst = 1'b0;
        check("R1 second reset");

        finish_run();
    end
endmodule